// File: doc/BRIEF.md
# Three-Channel Direction and Latch Controller

This block is the digital control core of a three-channel bidirectional signal translator. Every channel joins an A-side port and a B-side port. For each port the block produces a drive enable and a drive value, which the pad ring turns into a tristate buffer. A per-channel direction input picks which side receives and which side drives. Two mode inputs choose among four operating modes. The same two inputs also produce a regulator-enable output for the supply that feeds the B side.

In latch mode, data flowing from B to A is not passed through directly. Instead it is captured on a shared latch clock. That clock is sampled in the system clock domain, and a rising edge is found by comparing the current sample with the previous one. A thermal-fault input overrides every other input and forces all six ports to high impedance. All inputs are treated as synchronous to the system clock.

Top module: `xlat_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every channel's latch bit to 0 and clears the latch-clock sample to 0. After reset, a B-to-A channel in latch mode drives 0 on its A side until it sees the first captured rising edge.
- R2: Mode inputs {mode_en_a, mode_en_b} = 00 deassert all six drive enables and deassert reg_en.
- R3: Mode 01 deasserts all six drive enables and asserts reg_en.
- R4: In mode 10, reg_en is 1. A channel with dir_i = 0 drives a_out equal to b_in in the same cycle, and the latch clock has no effect.
- R5: In mode 11, reg_en is 1. When latch_clk is sampled high after a low sample, every B-to-A channel copies its b_in into its latch bit, and a_out shows the new value from the next clock edge on.
- R6: In mode 11, a falling edge of latch_clk, or latch_clk held at either level, leaves the latched A outputs unchanged.
- R7: A channel with dir_i = 1 in mode 10 or 11 drives b_out = a_in with b_oe = 1 and a_oe = 0. Edges of the latch clock do not change that channel's latch bit.
- R8: When therm_fault = 1, all a_oe and b_oe bits are 0 in every mode. No latch bit is captured while the fault is present.
- R9: On each channel, a_oe and b_oe are never 1 together. Only the driving side's enable can be 1.
- R10: When a channel in mode 11 switches from A-to-B to B-to-A, its A output shows the value latched earlier until the next captured rising edge.
- R11: Any port whose drive enable is 0 has a drive value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en_a | input | 1 | Mode input, upper bit of the mode code |
| mode_en_b | input | 1 | Mode input, lower bit of the mode code |
| dir_i | input | NUM_CH | Per-channel direction: 1 = A to B, 0 = B to A |
| latch_clk | input | 1 | Shared latch clock, sampled by clk |
| therm_fault | input | 1 | Thermal fault: forces all ports to high impedance |
| a_in | input | NUM_CH | Levels received on the A-side ports |
| b_in | input | NUM_CH | Levels received on the B-side ports |
| a_oe | output | NUM_CH | A-side drive enables |
| a_out | output | NUM_CH | A-side drive values |
| b_oe | output | NUM_CH | B-side drive enables |
| b_out | output | NUM_CH | B-side drive values |
| reg_en | output | 1 | Regulator enable |

## Verification
The hardest situation to reach from the ports is a latch bit that holds a value other than the current B level while its channel is not receiving. This state has to be built on purpose. The stimulus first captures a pattern with every channel set to B-to-A. It then turns two channels to A-to-B and fires a latch-clock edge, so only the third channel captures. Finally it turns all channels back with the latch clock held high, so a_out shows a mixture of old and new bits. The same held-high level is then carried through a thermal fault, to show that an edge arriving during the fault is lost rather than replayed later.

// File: rtl/xlat_pkg.sv
// Package: shared mode encoding for the translator controller.
// Assumes the mode code is {mode_en_a, mode_en_b}.
package xlat_pkg;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_REG_ONLY = 2'b01,
        MODE_PASS     = 2'b10,
        MODE_LATCH    = 2'b11
    } xlat_mode_t;

endpackage

// File: rtl/xlat_mode_dec.sv
// Module: decodes the two mode inputs and the thermal fault into
// regulator enable, port enable and latch/pass select.
// Assumes all inputs are synchronous to the system clock.
module xlat_mode_dec
    import xlat_pkg::*;
(
    input  logic mode_en_a,
    input  logic mode_en_b,
    input  logic therm_fault,
    output logic reg_en,
    output logic port_en,
    output logic latch_mode
);

    xlat_mode_t mode;

    // Purpose: form the mode code and decode its controls.
    always_comb begin
        mode       = xlat_mode_t'({mode_en_a, mode_en_b});
        reg_en     = (mode != MODE_OFF);
        port_en    = ((mode == MODE_PASS) || (mode == MODE_LATCH)) && !therm_fault;
        latch_mode = (mode == MODE_LATCH);
    end

endmodule

// File: rtl/xlat_edge_det.sv
// Module: samples the latch clock in the system clock domain and flags
// a rising edge when the current level is high and the previous sample low.
// Assumes the latch clock is already synchronous to clk.
module xlat_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_clk,
    output logic rise
);

    logic lclk_q;

    // Purpose: hold the previous latch-clock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) lclk_q <= 1'b0;
        else        lclk_q <= latch_clk;
    end

    // Purpose: compare the current level with the previous sample.
    always_comb rise = latch_clk && !lclk_q;

endmodule

// File: rtl/xlat_chan.sv
// Module: one translator channel. Produces the drive enable and value for
// both sides and holds the single latch bit used for B-to-A in latch mode.
// Assumes port_en already folds in the thermal fault.
module xlat_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic latch_mode,
    input  logic dir,
    input  logic rise,
    input  logic a_in,
    input  logic b_in,
    output logic a_oe,
    output logic a_out,
    output logic b_oe,
    output logic b_out
);

    logic store_q;
    logic capture;

    // Purpose: decide when the latch bit takes the B level.
    always_comb capture = port_en && latch_mode && !dir && rise;

    // Purpose: latch bit, cleared by reset, loaded on a captured edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       store_q <= 1'b0;
        else if (capture) store_q <= b_in;
    end

    // Purpose: drive enables and values for both sides.
    always_comb begin
        a_oe  = port_en && !dir;
        b_oe  = port_en && dir;
        a_out = a_oe ? (latch_mode ? store_q : b_in) : 1'b0;
        b_out = b_oe ? a_in : 1'b0;
    end

    AST_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (store_q == $past(b_in))); // R5

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(store_q)); // R6

    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && !latch_mode && !dir) |-> (a_out == b_in)); // R4

endmodule

// File: rtl/xlat_ctrl.sv
// Module: top of the three-channel direction and latch controller.
// Combines the mode decoder, the latch-clock edge detector and one
// channel slice per channel. Assumes all inputs are synchronous to clk.
module xlat_ctrl #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en_a,
    input  logic              mode_en_b,
    input  logic [NUM_CH-1:0] dir_i,
    input  logic              latch_clk,
    input  logic              therm_fault,
    input  logic [NUM_CH-1:0] a_in,
    input  logic [NUM_CH-1:0] b_in,
    output logic [NUM_CH-1:0] a_oe,
    output logic [NUM_CH-1:0] a_out,
    output logic [NUM_CH-1:0] b_oe,
    output logic [NUM_CH-1:0] b_out,
    output logic              reg_en
);

    localparam logic [NUM_CH-1:0] NO_DRIVE = '0;

    logic port_en;
    logic latch_mode;
    logic rise;

    xlat_mode_dec u_dec (
        .mode_en_a  (mode_en_a),
        .mode_en_b  (mode_en_b),
        .therm_fault(therm_fault),
        .reg_en     (reg_en),
        .port_en    (port_en),
        .latch_mode (latch_mode)
    );

    xlat_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_clk(latch_clk),
        .rise     (rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        xlat_chan u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .port_en   (port_en),
            .latch_mode(latch_mode),
            .dir       (dir_i[c]),
            .rise      (rise),
            .a_in      (a_in[c]),
            .b_in      (b_in[c]),
            .a_oe      (a_oe[c]),
            .a_out     (a_out[c]),
            .b_oe      (b_oe[c]),
            .b_out     (b_out[c])
        );
    end

    AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en_a |-> ((a_oe == NO_DRIVE) && (b_oe == NO_DRIVE))); // R2

    AST_FAULT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        therm_fault |-> ((a_oe == NO_DRIVE) && (b_oe == NO_DRIVE))); // R8

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_oe & b_oe) == NO_DRIVE)); // R9

    AST_QUIET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        (((a_out & ~a_oe) == NO_DRIVE) && ((b_out & ~b_oe) == NO_DRIVE))); // R11

endmodule

// File: tb/xlat_ctrl_tb_top.sv
// Bench: walks a table of stimulus/expected vectors, then runs directed
// reset and latch checks. Inputs change and outputs are sampled at negedge.
module xlat_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 3;
    localparam int NVEC = 15;

    // {en_a,en_b, fault, dir[3], lclk, a[3], b[3], aoe[3], aout[3], boe[3], bout[3], reg}
    localparam logic [25:0] VEC [NVEC] = '{
        26'b00_0_000_0_101_011_000_000_000_000_0, // 0  R2
        26'b01_0_000_0_101_011_000_000_000_000_1, // 1  R3
        26'b10_0_000_0_101_011_111_011_000_000_1, // 2  R4
        26'b10_0_000_1_101_110_111_110_000_000_1, // 3  R4 clock ignored
        26'b10_0_101_0_011_110_010_010_101_001_1, // 4  R7
        26'b11_0_000_0_011_111_111_000_000_000_1, // 5  R1 nothing captured yet
        26'b11_0_000_1_011_101_111_101_000_000_1, // 6  R5
        26'b11_0_000_0_011_010_111_101_000_000_1, // 7  R6 falling
        26'b11_0_000_0_011_000_111_101_000_000_1, // 8  R6 low held
        26'b11_0_011_1_110_000_100_000_011_010_1, // 9  R7 partial capture
        26'b11_0_000_1_110_110_111_001_000_000_1, // 10 R10
        26'b11_1_000_0_110_110_000_000_000_000_1, // 11 R8
        26'b11_1_000_1_110_110_000_000_000_000_1, // 12 R8 edge lost
        26'b11_0_000_1_110_110_111_001_000_000_1, // 13 R8 no replay
        26'b00_0_000_0_110_110_000_000_000_000_0  // 14 R2
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         mode_en_a, mode_en_b, latch_clk, therm_fault;
    logic [N-1:0] dir_i, a_in, b_in;
    logic [N-1:0] a_oe, a_out, b_oe, b_out;
    logic         reg_en;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_ctrl #(.NUM_CH(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_en_a(mode_en_a), .mode_en_b(mode_en_b),
        .dir_i(dir_i), .latch_clk(latch_clk), .therm_fault(therm_fault),
        .a_in(a_in), .b_in(b_in), .a_oe(a_oe), .a_out(a_out),
        .b_oe(b_oe), .b_out(b_out), .reg_en(reg_en)
    );

    function automatic string vec_req(int i);
        case (i)
            0, 14:        return "R2";
            1:            return "R3";
            2, 3:         return "R4";
            4, 9:         return "R7";
            5:            return "R1";
            6:            return "R5";
            7, 8:         return "R6";
            10:           return "R10";
            default:      return "R8";
        endcase
    endfunction

    task automatic check(string req, logic [12:0] act, logic [12:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act aoe/aout/boe/bout/reg=%b expected %b", req, act, exp);
        end
    endtask

    task automatic check_r9(string tag);
        total++;
        if ((a_oe & b_oe) != '0) begin
            bad++;
            $display("FAIL R9 (%s): a_oe=%b b_oe=%b expected no overlap", tag, a_oe, b_oe);
        end
    endtask

    function automatic logic [12:0] outs();
        return {a_oe, a_out, b_oe, b_out, reg_en};
    endfunction

    task automatic drive(logic [12:0] s);
        {mode_en_a, mode_en_b, therm_fault, dir_i, latch_clk, a_in, b_in} = s;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(13'b0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R1 / R2: reset state with mode 00
        check("R1", outs(), 13'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][25:13]);
            @(posedge clk); @(negedge clk);
            check(vec_req(i), outs(), VEC[i][12:0]);
            check_r9(vec_req(i));
        end

        // R5: capture 111 in latch mode
        drive(13'b11_0_000_0_000_111); @(posedge clk); @(negedge clk);
        drive(13'b11_0_000_1_000_111); @(posedge clk); @(negedge clk);
        check("R5", outs(), 13'b111_111_000_000_1);
        // R1: reset clears latch bits and the edge sample
        rst_n = 1'b0;
        drive(13'b11_0_000_0_000_111);
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", outs(), 13'b111_000_000_000_1);
        // R1: edge sample cleared, so high level after reset counts as a rise
        rst_n = 1'b0;
        drive(13'b11_0_000_1_000_110);
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", outs(), 13'b111_110_000_000_1);
        // R11: pass mode A-to-B, undriven A values stay 0
        drive(13'b10_0_111_0_101_111); @(posedge clk); @(negedge clk);
        check("R11", outs(), 13'b000_000_111_101_1);
        check_r9("R11");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule